// File: doc/BRIEF.md
# Prescaled Timer/Counter with Atomic 16-bit Access

This block is a small timer/counter peripheral that sits on a byte-wide register bus. In timer mode it advances once for each instruction-cycle strobe. In counter mode it advances on edges of an external input pin. That pin first passes through a synchronizer and an edge detector, and a control bit chooses whether rising or falling edges count. An optional power-of-two prescaler can be placed in front of the count. The count is either 8 or 16 bits wide.

Software reaches the count through a low-byte register and a high-byte buffer register. Reading the low byte captures the live high byte into the buffer. Writing the low byte commits the buffer into the live high byte. This keeps 16-bit accesses coherent across a carry. A wrap of the count sets a sticky interrupt flag, and an enable bit gates that flag onto the interrupt output. After any write to the count, the next two instruction-cycle strobes produce no increment.

Top module: `tick_counter`

## Requirements
- R1: After reset the count, high-byte buffer, control register, flag and enable are all zero, and `irq` is low.
- R2: In timer mode (control bit 5 = 0) with the prescaler bypassed (control bit 3 = 1), the count increases by exactly one per `cyc_stb` pulse and does not change on clocks without a strobe.
- R3: In counter mode (control bit 5 = 1), only synchronized pin edges count and strobes are ignored. Control bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges.
- R4: When control bit 3 = 0, increments happen once every 2^(k+1) source events, where k is control bits 2:0. Any write to the count clears the prescaler but leaves the control register unchanged.
- R5: A write to address 0 (low byte) blocks counting for the next two `cyc_stb` pulses. The first increment after the write comes with the third strobe.
- R6: When control bit 7 (run) is 0, the count holds its value.
- R7: When control bit 6 = 0 (8-bit mode), only the low byte counts. A wrap of the low byte from FFh to 00h sets the flag, and the high byte is left unchanged.
- R8: When control bit 6 = 1 (16-bit mode), the flag is set only on the wrap from FFFFh to 0000h. A carry from 00FFh to 0100h does not set it.
- R9: Address 3 holds the flag in bit 0 and the enable in bit 1. The flag stays set until software writes 0 to bit 0. `irq` is high exactly when both bits are set.
- R10: A read of address 0 returns the live low byte and loads the live high byte into the buffer at address 1. A later read of address 1 returns that captured byte even if a carry has happened since.
- R11: A write to address 1 changes only the buffer. A write to address 0 in 16-bit mode loads the buffer and the written byte into the count together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | Instruction-cycle strobe |
| ext_pin | input | 1 | External count input, asynchronous |
| bus_addr | input | 2 | Register select: 0 low, 1 high buffer, 2 control, 3 interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 0 captures the high byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
The hardest situation to reach is a low-byte read that lands exactly one cycle before a carry into the high byte, because only then does a torn read differ from a coherent one. The bench gets there by writing a known count while running and counting clock edges through the two inhibited strobes. The read then samples FFh and the capture shares an edge with the carry. Prescaler ratios are covered by random ratio, bypass and window-length choices. Each window is closed by stopping the count on a known edge, so the expected value follows exactly from the number of edges.

// File: rtl/tick_counter_pkg.sv
`timescale 1ns/1ps
package tick_counter_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_LOW  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_HBUF = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_INT  = 2'd3;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       run;
        logic       wide;
        logic       pin_src;
        logic       fall;
        logic       bypass;
        logic [2:0] ratio;
    } ctrl_t;
endpackage

// File: rtl/tick_edge_sync.sv
`timescale 1ns/1ps
module tick_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_o = fall_i ? (sh_q[STAGES] & ~sh_q[STAGES-1])
                           : (sh_q[STAGES-1] & ~sh_q[STAGES]);

    // a detected edge is a single-cycle pulse unless the polarity flips
    assert_edge_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || (fall_i != $past(fall_i))));
endmodule

// File: rtl/tick_prescale.sv
`timescale 1ns/1ps
module tick_prescale #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic             clr_i,
    input  logic             bypass_i,
    input  logic [SEL_W-1:0] ratio_i,
    output logic             inc_o
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] nxt, mask;

    always_comb begin
        nxt   = pre_q + 1'b1;
        mask  = PRE_W'((32'd1 << (32'(ratio_i) + 32'd1)) - 32'd1);
        pre_d = pre_q;
        inc_o = 1'b0;
        if (clr_i) begin
            pre_d = '0;
        end else if (ev_i) begin
            if (bypass_i) begin
                inc_o = 1'b1;
            end else begin
                pre_d = nxt;
                inc_o = ((nxt & mask) == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assert_pre_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));
    assert_pre_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter
    import tick_counter_pkg::*;
#(
    parameter int PRE_W          = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int INHIBIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              ext_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int INH_W = $clog2(INHIBIT_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] hbuf;
        ctrl_t             ctrl;
        logic              flag;
        logic              ien;
        logic [INH_W-1:0]  inh;
    } state_t;

    state_t st_d, st_q;

    logic pin_edge, ev, inc, low_wr, wrap;
    logic [CNT_W-1:0] cnt_inc;

    tick_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .fall_i (st_q.ctrl.fall),
        .edge_o (pin_edge)
    );

    assign low_wr = bus_wr && (bus_addr == ADR_LOW);
    assign ev     = st_q.ctrl.run && (st_q.inh == '0)
                    && (st_q.ctrl.pin_src ? pin_edge : cyc_stb);

    tick_prescale #(.PRE_W(PRE_W), .SEL_W(3)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .clr_i    (low_wr),
        .bypass_i (st_q.ctrl.bypass),
        .ratio_i  (st_q.ctrl.ratio),
        .inc_o    (inc)
    );

    always_comb begin
        st_d = st_q;

        cnt_inc = st_q.ctrl.wide ? st_q.cnt + 1'b1
                                 : {st_q.cnt[CNT_W-1:BYTE_W], st_q.cnt[BYTE_W-1:0] + 1'b1};
        wrap    = st_q.ctrl.wide ? (&st_q.cnt) : (&st_q.cnt[BYTE_W-1:0]);

        if (cyc_stb && (st_q.inh != '0)) st_d.inh = st_q.inh - 1'b1;

        if (inc) st_d.cnt = cnt_inc;

        if (bus_rd && (bus_addr == ADR_LOW)) st_d.hbuf = st_q.cnt[CNT_W-1:BYTE_W];

        if (bus_wr) begin
            unique case (bus_addr)
                ADR_LOW: begin
                    st_d.cnt = {(st_q.ctrl.wide ? st_q.hbuf : st_q.cnt[CNT_W-1:BYTE_W]), bus_wdata};
                    st_d.inh = INH_W'(INHIBIT_CYCLES);
                end
                ADR_HBUF: st_d.hbuf = bus_wdata;
                ADR_CTRL: st_d.ctrl = ctrl_t'(bus_wdata);
                ADR_INT: begin
                    st_d.flag = bus_wdata[0];
                    st_d.ien  = bus_wdata[1];
                end
                default: ;
            endcase
        end

        if (inc && wrap && !low_wr) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADR_LOW:  bus_rdata = st_q.cnt[BYTE_W-1:0];
                ADR_HBUF: bus_rdata = st_q.hbuf;
                ADR_CTRL: bus_rdata = st_q.ctrl;
                ADR_INT:  bus_rdata = {{(BYTE_W-2){1'b0}}, st_q.ien, st_q.flag};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = st_q.flag & st_q.ien;

    assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.inh != '0) && !low_wr) |=> $stable(st_q.cnt));
    assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !low_wr) |=> $stable(st_q.cnt));
    assert_wide_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_wr && st_q.ctrl.wide && (&st_q.cnt)) |=> ((&st_q.cnt) || st_q.flag));
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ien |-> !irq);
    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADR_LOW)) |=> (st_q.hbuf == $past(st_q.cnt[CNT_W-1:BYTE_W])));
    assert_narrow_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.wide && !low_wr) |=> $stable(st_q.cnt[CNT_W-1:BYTE_W]));
endmodule

// File: tb/test_tick_counter.sv
`timescale 1ns/1ps
module test_tick_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b1;
    logic       ext_pin = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tick_counter i_tick_counter (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_pin(ext_pin),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] ctl(input bit run, input bit wide, input bit src,
                                       input bit fall, input bit byp, input int r);
        return {run, wide, src, fall, byp, 3'(r)};
    endfunction

    function automatic int exp_count(input int j, input bit byp, input int r);
        if (byp) return j - 1;
        return (j - 1) >> (r + 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse();
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] lo, hi, d;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, d); chk("R1 ctrl", d, 0);
        rd(2'd3, d); chk("R1 int reg", d, 0);
        rd(2'd0, d); chk("R1 low", d, 0);
        rd(2'd1, d); chk("R1 hbuf", d, 0);
        chk("R1 irq", irq, 0);

        // R5 write inhibit, sampled every cycle
        wr(2'd2, ctl(1,1,0,0,1,0));
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h10);
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1 chk("R5 inhibit k0", bus_rdata, 8'h10);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            #1 chk("R5 inhibit", bus_rdata, 8'h10 + ((k > 2) ? k - 2 : 0));
        end
        bus_rd = 1'b0;

        // R2 strobe-paced counting
        cyc_stb = 1'b0;
        wr(2'd0, 8'h00);
        repeat (20) @(negedge clk);
        rd(2'd0, d); chk("R2 no strobe", d, 0);
        for (int k = 0; k < 20; k++) begin
            cyc_stb = 1'b1; @(negedge clk);
            cyc_stb = 1'b0; @(negedge clk);
        end
        rd(2'd0, d); chk("R2 per strobe", d, 18);
        cyc_stb = 1'b1;

        // R7 narrow wrap, high byte kept
        wr(2'd2, ctl(0,1,0,0,1,0));
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h02);
        wr(2'd2, ctl(1,0,0,0,1,0));
        wr(2'd0, 8'hFE);
        bus_addr = 2'd0; bus_rd = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R7 low FF", bus_rdata, 8'hFF); chk("R7 no irq yet", irq, 0);
        @(negedge clk);
        #1 chk("R7 wrap low", bus_rdata, 8'h00); chk("R7 wrap irq", irq, 1);
        bus_rd = 1'b0;
        wr(2'd2, ctl(0,0,0,0,1,0));
        rd(2'd0, d);
        rd(2'd1, hi); chk("R7 high kept", hi, 8'h55);

        // R8 carry without flag, then full wrap
        wr(2'd3, 8'h02);
        wr(2'd2, ctl(1,1,0,0,1,0));
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFE);
        repeat (4) @(negedge clk);
        #1 chk("R8 carry no irq", irq, 0);
        wr(2'd2, ctl(0,1,0,0,1,0));
        rd(2'd0, lo); rd(2'd1, hi);
        chk("R8 carry value", {hi, lo}, 16'h0101);
        wr(2'd2, ctl(1,1,0,0,1,0));
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFE);
        repeat (3) @(negedge clk);
        #1 chk("R8 before wrap", irq, 0);
        @(negedge clk);
        #1 chk("R8 wrap irq", irq, 1);

        // R9 flag sticky, enable gating, clear
        wr(2'd3, 8'h01);
        chk("R9 gated off", irq, 0);
        rd(2'd3, d); chk("R9 flag kept", d, 8'h01);
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R9 cleared", d, 8'h00);

        // R10 coherent read across carry
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFD);
        repeat (4) @(negedge clk);
        rd(2'd0, lo); chk("R10 low FF", lo, 8'hFF);
        rd(2'd1, hi); chk("R10 captured high", hi, 8'h00);
        rd(2'd0, lo);
        rd(2'd1, hi); chk("R10 later high", hi, 8'h01);

        // R11 buffer-only write, atomic commit; R6 stopped
        wr(2'd2, ctl(0,1,0,0,1,0));
        wr(2'd1, 8'h12); wr(2'd0, 8'h34);
        wr(2'd1, 8'h99);
        rd(2'd0, lo); rd(2'd1, hi);
        chk("R11 buffer only", {hi, lo}, 16'h1234);
        wr(2'd1, 8'hAB); wr(2'd0, 8'hCD);
        repeat (30) @(negedge clk);
        rd(2'd0, lo); rd(2'd1, hi);
        chk("R11 commit", {hi, lo}, 16'hABCD);
        chk("R6 stopped", lo, 8'hCD);

        // R3 counter mode, rising then falling
        wr(2'd2, ctl(1,1,1,0,1,0));
        wr(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5; k++) pulse();
        rd(2'd0, d); chk("R3 rising count", d, 5);
        wr(2'd2, ctl(1,1,1,1,1,0));
        wr(2'd0, 8'h00);
        ext_pin = 1'b1; repeat (8) @(negedge clk);
        rd(2'd0, d); chk("R3 falling ignores rise", d, 0);
        ext_pin = 1'b0; repeat (8) @(negedge clk);
        rd(2'd0, d); chk("R3 falling counts fall", d, 1);
        // R4 prescaler on pin edges
        wr(2'd2, ctl(1,1,1,0,0,0));
        wr(2'd0, 8'h00);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) pulse();
        rd(2'd0, d); chk("R4 pin div2", d, 3);

        // R4 random ratios and windows in timer mode
        for (int it = 0; it < 14; it++) begin
            int r, j;
            bit byp;
            r   = $urandom % 8;
            byp = (($urandom % 4) == 0);
            j   = 2 + ($urandom % 600);
            if (it == 0) begin r = 7; byp = 1'b0; j = 600; end
            wr(2'd2, ctl(1,1,0,0,byp,r));
            wr(2'd1, 8'h00);
            wr(2'd0, 8'h00);
            rd(2'd2, d); chk("R4 ctrl unchanged", d, ctl(1,1,0,0,byp,r));
            repeat (j - 1) @(negedge clk);
            wr(2'd2, ctl(0,1,0,0,byp,r));
            rd(2'd0, lo); rd(2'd1, hi);
            chk("R4 prescaled count", {hi, lo}, exp_count(j, byp, r));
        end

        summary();
        $finish;
    end
endmodule